// File: doc/BRIEF.md
# Exception Priority Resolution Unit

This block looks at every exception request that is pending in a given cycle, picks the most urgent one, and decides whether that request may interrupt the code that is running. Three fixed-level sources are always more urgent than any programmable source: reset, the non-maskable interrupt and hard fault. A parameterised number of programmable sources each carry an 8-bit priority field.

A programmable group setting splits each priority field into a preemption part and a subpriority part. Only the preemption part is compared against the running level. The subpriority only orders requests that share a preemption level.

Three mask registers can raise the effective running level: a global mask, a fault mask and a base-priority threshold. The threshold also has a write alias that can only tighten it. Software reaches all settings through a plain write/read register port. The winner, its priority and the preempt decision are registered, so they reflect the inputs of the previous cycle.

Top module: `exc_prio_arbiter`

## Requirements
- R1: After reset, `win_num_o` is 0, `win_prio_o` is 256, `preempt_o` is 0, and every register reads 0.
- R2: The register map is as follows. Writing address i < NUM_SRC sets the priority of programmable source i. Only the top PRIO_BITS bits of the written byte are stored, and the lower bits always read back as zero. Address NUM_SRC+0 holds the group (bits 2:0), NUM_SRC+1 the global mask (bit 0), NUM_SRC+2 the fault mask (bit 0), NUM_SRC+3 the base threshold (implemented bits only), and NUM_SRC+4 the max-only alias of the threshold, which reads back as the threshold. Any other address reads 0 and ignores writes.
- R3: The winner is the pending request with the numerically smallest priority. Reset is number 1 at level -3, NMI is number 2 at level -2 and hard fault is number 3 at level -1. Programmable source i is number 16+i, with its stored field as its level.
- R4: When several pending requests have the same priority value, the lowest exception number wins.
- R5: With group g, the preemption part of a level is the level with bits g..0 cleared. The fixed negative levels are left unchanged. A winner preempts only when its preemption part is strictly smaller than that of `run_level_i`, where 256 means no exception is running. A winner with an equal part, or one that differs only in subpriority, does not preempt.
- R6: While the global mask is set, the effective running level is at most 0, so only the fixed-level sources can preempt.
- R7: While the fault mask is set, the effective running level is -1, so only reset and NMI can preempt. A pulse on `exc_exit_i` clears the fault mask, and it overrides a write to that mask in the same cycle.
- R8: A nonzero threshold limits the effective running level to the preemption part of the threshold. A threshold of 0 masks nothing.
- R9: A write to the max-only alias stores the new implemented value only if that value is nonzero and either the threshold is 0 or the new value is smaller than the threshold. Otherwise the threshold is left unchanged.
- R10: The winner outputs and `preempt_o` are registered. They reflect the pending inputs, `run_level_i` and the register contents seen at the previous rising clock edge.
- R11: With nothing pending, `win_num_o` is 0, `win_prio_o` is 256 and `preempt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_fixed_i | input | 3 | Pending fixed sources: bit 0 reset, bit 1 NMI, bit 2 hard fault |
| pend_i | input | NUM_SRC | Pending programmable sources |
| run_level_i | input | LW (signed) | Priority of the running exception, 256 when none is running |
| exc_exit_i | input | 1 | Exception-exit pulse, clears the fault mask |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | AW | Register read address |
| rd_data_o | output | 8 | Combinational read data |
| win_num_o | output | EXC_W | Winning exception number, 0 when none |
| win_prio_o | output | LW (signed) | Priority value of the winner, 256 when none |
| preempt_o | output | 1 | Winner may preempt the running code |

## Verification
Several situations are hard to reach from the ports. One is a fault-mask write landing in the same cycle as an exit pulse. Another is a sequence of max-only alias writes that alternately tighten the threshold and are rejected. A third is a group setting that makes two distinct priority values share one preemption part, so that only the subpriority decides. Directed phases set each of these up by holding the pending vector and running level steady while single register writes are issued. A long pseudo-random phase then mixes writes, exits, fixed requests and running levels. Throughout, a behavioural reference compares every output on every cycle.

// File: rtl/exc_prio_arbiter.sv
module exc_prio_arbiter #(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 4,
  parameter int LW        = 10,
  localparam int AW    = $clog2(NUM_SRC + 6),
  localparam int EXC_W = $clog2(16 + NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           pend_fixed_i,
  input  logic [NUM_SRC-1:0]   pend_i,
  input  logic signed [LW-1:0] run_level_i,
  input  logic                 exc_exit_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [7:0]           rd_data_o,
  output logic [EXC_W-1:0]     win_num_o,
  output logic signed [LW-1:0] win_prio_o,
  output logic                 preempt_o
);
  localparam logic [15:0]          IMPL_W = 16'hFF00 >> PRIO_BITS;
  localparam logic [7:0]           IMPL   = IMPL_W[7:0];
  localparam logic signed [LW-1:0] IDLE   = LW'(256);
  localparam logic [AW-1:0] A_GRP  = AW'(NUM_SRC);
  localparam logic [AW-1:0] A_PM   = AW'(NUM_SRC + 1);
  localparam logic [AW-1:0] A_FM   = AW'(NUM_SRC + 2);
  localparam logic [AW-1:0] A_BASE = AW'(NUM_SRC + 3);
  localparam logic [AW-1:0] A_BMAX = AW'(NUM_SRC + 4);

  logic [7:0] prio_q [NUM_SRC];
  logic [2:0] grp_q;
  logic       pmask_q, fmask_q;
  logic [7:0] base_q;

  wire [7:0] wd_impl = wr_data_i & IMPL;

  function automatic logic signed [LW-1:0] preempt_part(input logic signed [LW-1:0] v,
                                                        input logic [2:0] g);
    logic [LW-1:0] m;
    m = ~((LW'(2) << g) - LW'(1));
    if (v < 0 || v > LW'(255)) return v;
    return $signed($unsigned(v) & m);
  endfunction

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n) prio_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i)) prio_q[i] <= wd_impl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q   <= '0;
      pmask_q <= 1'b0;
      fmask_q <= 1'b0;
      base_q  <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_GRP) grp_q <= wr_data_i[2:0];
      if (wr_en_i && wr_addr_i == A_PM) pmask_q <= wr_data_i[0];
      if (exc_exit_i) fmask_q <= 1'b0;
      else if (wr_en_i && wr_addr_i == A_FM) fmask_q <= wr_data_i[0];
      if (wr_en_i && wr_addr_i == A_BASE) base_q <= wd_impl;
      else if (wr_en_i && wr_addr_i == A_BMAX && wd_impl != 8'd0 &&
               (base_q == 8'd0 || wd_impl < base_q)) base_q <= wd_impl;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = prio_q[i];
    if (rd_addr_i == A_GRP)  rd_data_o = {5'd0, grp_q};
    if (rd_addr_i == A_PM)   rd_data_o = {7'd0, pmask_q};
    if (rd_addr_i == A_FM)   rd_data_o = {7'd0, fmask_q};
    if (rd_addr_i == A_BASE || rd_addr_i == A_BMAX) rd_data_o = base_q;
  end

  logic                 found;
  logic [EXC_W-1:0]     best_num;
  logic signed [LW-1:0] best_lvl, cur_lvl, base_lvl;

  always_comb begin
    found    = 1'b0;
    best_num = '0;
    best_lvl = IDLE;
    for (int k = 0; k < 3; k++) begin
      if (pend_fixed_i[k] && (!found || ($signed(LW'(k)) - $signed(LW'(3))) < best_lvl)) begin
        found    = 1'b1;
        best_num = EXC_W'(k + 1);
        best_lvl = $signed(LW'(k)) - $signed(LW'(3));
      end
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (!found || $signed({{(LW-8){1'b0}}, prio_q[i]}) < best_lvl)) begin
        found    = 1'b1;
        best_num = EXC_W'(16 + i);
        best_lvl = $signed({{(LW-8){1'b0}}, prio_q[i]});
      end
    end
  end

  always_comb begin
    base_lvl = preempt_part($signed({{(LW-8){1'b0}}, base_q}), grp_q);
    cur_lvl  = preempt_part(run_level_i, grp_q);
    if (base_q != 8'd0 && base_lvl < cur_lvl) cur_lvl = base_lvl;
    if (pmask_q && cur_lvl > 0) cur_lvl = '0;
    if (fmask_q) cur_lvl = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_num_o  <= '0;
      win_prio_o <= IDLE;
      preempt_o  <= 1'b0;
    end else begin
      win_num_o  <= best_num;
      win_prio_o <= best_lvl;
      preempt_o  <= found && (preempt_part(best_lvl, grp_q) < cur_lvl);
    end
  end
endmodule

module exc_prio_arbiter_chk #(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 4,
  parameter int LW        = 10,
  localparam int AW    = $clog2(NUM_SRC + 6),
  localparam int EXC_W = $clog2(16 + NUM_SRC)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           pend_fixed_i,
  input logic [NUM_SRC-1:0]   pend_i,
  input logic                 exc_exit_i,
  input logic                 wr_en_i,
  input logic [AW-1:0]        wr_addr_i,
  input logic [AW-1:0]        rd_addr_i,
  input logic [7:0]           rd_data_o,
  input logic [EXC_W-1:0]     win_num_o,
  input logic signed [LW-1:0] win_prio_o,
  input logic                 preempt_o,
  input logic                 pmask_q,
  input logic                 fmask_q,
  input logic [7:0]           base_q
);
  localparam logic [15:0]          IMPL_W = 16'hFF00 >> PRIO_BITS;
  localparam logic [7:0]           LOW    = ~IMPL_W[7:0];
  localparam logic signed [LW-1:0] IDLE   = LW'(256);
  localparam logic signed [LW-1:0] ZERO   = '0;
  localparam logic signed [LW-1:0] NEG1   = '1;
  localparam logic [AW-1:0]        A_BMAX = AW'(NUM_SRC + 4);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    win_num_o == '0 |-> !preempt_o && win_prio_o == IDLE);  // R11
  AST_NOTHING_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|{pend_fixed_i, pend_i}) |-> win_num_o == '0);  // R11
  AST_PMASK_FIXED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pmask_q) && preempt_o |-> win_prio_o < ZERO);  // R6
  AST_FMASK_NMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fmask_q) && preempt_o |-> win_prio_o < NEG1);  // R7
  AST_FMASK_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_exit_i |=> !fmask_q);  // R7
  AST_BMAX_TIGHTEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_addr_i == A_BMAX && base_q != 8'd0 |=>
      base_q != 8'd0 && base_q <= $past(base_q));  // R9
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_i < AW'(NUM_SRC) |-> (rd_data_o & LOW) == 8'd0);  // R2
endmodule

bind exc_prio_arbiter exc_prio_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .LW(LW)
) u_chk (.*);

// File: tb/exc_prio_arbiter_test.sv
module exc_prio_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int PB = 4;
  localparam int LW = 10;
  localparam int AW = $clog2(NS + 6);
  localparam int EW = $clog2(16 + NS);

  logic clk = 0, rst_n = 0;
  logic [2:0] pend_fixed_i = '0;
  logic [NS-1:0] pend_i = '0;
  logic signed [LW-1:0] run_level_i = LW'(256);
  logic exc_exit_i = 0, wr_en_i = 0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [EW-1:0] win_num_o;
  logic signed [LW-1:0] win_prio_o;
  logic preempt_o;

  exc_prio_arbiter #(.NUM_SRC(NS), .PRIO_BITS(PB), .LW(LW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_prio [NS];
  int m_grp, m_pm, m_fm, m_base;
  int e_num = 0, e_prio = 256, e_pre = 0;

  function automatic int impl(int v);
    return v - (v % (1 << (8 - PB)));
  endfunction
  function automatic int part(int v, int g);
    if (v < 0 || v > 255) return v;
    return v - (v % (2 << g));
  endfunction
  function automatic int mread(int a);
    if (a < NS) return m_prio[a];
    case (a - NS)
      0: return m_grp;
      1: return m_pm;
      2: return m_fm;
      3, 4: return m_base;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_prio[i]) m_prio[i] = 0;
      m_grp = 0; m_pm = 0; m_fm = 0; m_base = 0;
      e_num = 0; e_prio = 256; e_pre = 0;
    end else begin
      int bk, bn, bp, cur, key, wd, a;
      bk = 1 << 30; bn = 0; bp = 256;
      for (int k = 0; k < 3; k++)
        if (pend_fixed_i[k]) begin
          key = (k - 3) * 64 + k + 1;
          if (key < bk) begin bk = key; bn = k + 1; bp = k - 3; end
        end
      for (int i = 0; i < NS; i++)
        if (pend_i[i]) begin
          key = m_prio[i] * 64 + 16 + i;
          if (key < bk) begin bk = key; bn = 16 + i; bp = m_prio[i]; end
        end
      cur = part(int'(run_level_i), m_grp);
      if (m_base != 0) cur = (part(m_base, m_grp) < cur) ? part(m_base, m_grp) : cur;
      if (m_pm != 0 && cur > 0) cur = 0;
      if (m_fm != 0) cur = -1;
      e_num = bn; e_prio = bp;
      e_pre = (bn != 0 && part(bp, m_grp) < cur) ? 1 : 0;
      wd = int'(wr_data_i); a = int'(wr_addr_i);
      if (exc_exit_i) m_fm = 0;
      if (wr_en_i) begin
        if (a < NS) m_prio[a] = impl(wd);
        else if (a == NS) m_grp = wd % 8;
        else if (a == NS + 1) m_pm = wd % 2;
        else if (a == NS + 2) begin if (!exc_exit_i) m_fm = wd % 2; end
        else if (a == NS + 3) m_base = impl(wd);
        else if (a == NS + 4) begin
          if (impl(wd) != 0 && (m_base == 0 || impl(wd) < m_base)) m_base = impl(wd);
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (!done) begin
      bit bad;
      bad = 0;
      vectors++;
      if (int'(win_num_o) != e_num) begin
        bad = 1; $display("FAIL %s win_num actual=%0d expected=%0d", cur_req, win_num_o, e_num);
      end
      if (int'(win_prio_o) != e_prio) begin
        bad = 1; $display("FAIL %s win_prio actual=%0d expected=%0d", cur_req, win_prio_o, e_prio);
      end
      if (int'(preempt_o) != e_pre) begin
        bad = 1; $display("FAIL %s preempt actual=%0d expected=%0d", cur_req, preempt_o, e_pre);
      end
      if (int'(rd_data_o) != mread(int'(rd_addr_i))) begin
        bad = 1; $display("FAIL %s rd_data[%0d] actual=%0h expected=%0h", cur_req,
                          rd_addr_i, rd_data_o, mread(int'(rd_addr_i)));
      end
      if (bad) fails++;
    end
  end

  int rd_ctr = 0;
  task automatic tick(int n = 1);
    repeat (n) begin
      rd_addr_i = AW'(rd_ctr % (NS + 6));
      rd_ctr++;
      @(negedge clk);
    end
  endtask
  task automatic wr(int a, int d);
    wr_en_i = 1; wr_addr_i = AW'(a); wr_data_i = 8'(d);
    tick();
    wr_en_i = 0;
  endtask
  task automatic hold(logic [2:0] f, logic [NS-1:0] p, int run, int n = 3);
    pend_fixed_i = f; pend_i = p; run_level_i = LW'(run);
    tick(n);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); tick(3);
    cur_req = "R1"; rst_n = 1; tick(NS + 6);
    cur_req = "R2";
    for (int i = 0; i < NS; i++) wr(i, 8'hFF);
    tick(NS + 6);
    for (int i = 0; i < NS; i++) wr(i, ((7 - i) << 4) | 4'h9);
    tick(NS + 6);
    wr(NS + 5, 8'h55);
    cur_req = "R11"; hold(3'b000, '0, 256);
    cur_req = "R3";
    hold(3'b000, 8'b0000_0011, 256);
    hold(3'b000, 8'b1000_0001, 256);
    hold(3'b100, 8'hFF, 256);
    hold(3'b110, 8'hFF, -1);
    hold(3'b111, 8'h00, -2);
    cur_req = "R10";
    hold(3'b000, 8'b0000_0100, 256, 1);
    hold(3'b000, 8'b0100_0000, 256, 1);
    hold(3'b010, 8'b0000_0000, 256, 1);
    cur_req = "R4";
    wr(2, 8'h30); wr(5, 8'h30);
    hold(3'b000, 8'b0010_0100, 256);
    hold(3'b000, 8'b0010_0000, 256);
    cur_req = "R5";
    wr(NS, 4); wr(3, 8'h20);
    hold(3'b000, 8'b0000_1000, 8'h30);
    wr(3, 8'h10);
    hold(3'b000, 8'b0000_1000, 8'h30);
    wr(NS, 0); wr(3, 8'h20);
    hold(3'b000, 8'b0000_1000, 8'h30);
    hold(3'b000, 8'b0000_1000, 8'h20);
    wr(NS, 7);
    hold(3'b000, 8'b0000_1000, 256);
    hold(3'b000, 8'b0000_1000, 8'h40);
    wr(NS, 0);
    cur_req = "R6";
    wr(NS + 1, 1); wr(7, 8'h00);
    hold(3'b000, 8'b1000_0000, 256);
    hold(3'b100, 8'b1000_0000, 256);
    wr(NS + 1, 0);
    cur_req = "R7";
    wr(NS + 2, 1);
    hold(3'b100, 8'hFF, 256);
    hold(3'b010, 8'hFF, 256);
    exc_exit_i = 1; tick(); exc_exit_i = 0;
    hold(3'b100, 8'hFF, 256);
    wr(NS + 2, 1);
    exc_exit_i = 1; wr(NS + 2, 1); exc_exit_i = 0;
    hold(3'b100, 8'h00, 256);
    cur_req = "R8";
    wr(NS + 3, 8'h60); wr(1, 8'h60); wr(4, 8'h50);
    hold(3'b000, 8'b0000_0010, 256);
    hold(3'b000, 8'b0001_0000, 256);
    wr(NS, 5);
    hold(3'b000, 8'b0001_0000, 256);
    wr(NS, 0); wr(NS + 3, 0);
    hold(3'b000, 8'b0000_0010, 256);
    cur_req = "R9";
    wr(NS + 4, 8'h80); tick(2);
    wr(NS + 4, 8'hF0); tick(2);
    wr(NS + 4, 8'h40); tick(2);
    wr(NS + 4, 8'h00); tick(2);
    wr(NS + 4, 8'h4F); tick(2);
    hold(3'b000, 8'b0001_0000, 256);
    wr(NS + 3, 0);
    cur_req = "R10";
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom % 8;
      pend_fixed_i = ($urandom % 6 == 0) ? 3'($urandom) : 3'b000;
      pend_i = NS'($urandom) & NS'($urandom);
      case ($urandom % 4)
        0: run_level_i = LW'(256);
        1: run_level_i = LW'(-1 - int'($urandom % 3));
        default: run_level_i = LW'($urandom % 256);
      endcase
      exc_exit_i = ($urandom % 10 == 0);
      if (r < 2) begin
        wr_en_i = 1; wr_addr_i = AW'($urandom % (NS + 6)); wr_data_i = 8'($urandom);
      end
      tick();
      wr_en_i = 0; exc_exit_i = 0;
    end
    tick(3);
    finish_run();
  end
endmodule